// File: doc/BRIEF.md
# Start Event Source Selector

This block generates the one start pulse that launches every delay channel of a trigger-delay generator. Register `sel_i` chooses one of three event sources. The first is a digital external trigger, which is the output of a threshold comparator set elsewhere. The second is an internal phase-accumulator oscillator whose increment software writes directly. The third is a mains zero-crossing input followed by a programmable phase delay. A fourth code turns all starts off.

The whole block runs on the 100 MHz reference clock. Both asynchronous inputs pass through a two-flop synchroniser and a rising-edge detector. The selected event is registered onto `start_o` as a pulse one cycle wide. Any repetition rate is allowed. If a start is issued while the downstream delay logic still reports busy, `overrun_o` flags it, but the start is not suppressed.

Top module: `trig_src_top`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `start_o` and `overrun_o` are 0.
- R2: With `sel_i`=0 (external), a rising edge on `trig_i` first sampled at clock edge k drives `start_o` high for exactly one cycle after edge k+2. The pulse is one cycle wide however long `trig_i` stays high.
- R3: With `sel_i`=1 (oscillator), a 32-bit accumulator adds `nco_inc_i` every cycle, and each carry out of bit 31 is a start event. For an increment of 2^n, starts occur every 2^(32-n) cycles.
- R4: With `sel_i`=1 and `nco_inc_i`=0, no start is produced.
- R5: With `sel_i`=2 (mains), a rising edge on `zc_i` first sampled at edge k drives `start_o` high after edge k+3+`phase_i`. `phase_i` counts clock cycles. A new zero-crossing edge restarts the delay.
- R6: Only the selected source produces starts. With `sel_i`=3, no source does.
- R7: `start_o` is never high in two consecutive cycles: an event that coincides with an asserted `start_o` is dropped. A change of `sel_i` is adopted only in a cycle where `start_o` is low.
- R8: `overrun_o` is high exactly in the cycles where `start_o` is high and `busy_i` was high at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Source: 0 external, 1 oscillator, 2 mains, 3 off |
| nco_inc_i | input | 32 | Accumulator increment |
| phase_i | input | 16 | Mains phase delay in clock cycles |
| trig_i | input | 1 | Comparator output, asynchronous |
| zc_i | input | 1 | Mains zero-crossing detector, asynchronous |
| busy_i | input | 1 | Downstream delay logic still running |
| start_o | output | 1 | One-cycle start pulse |
| overrun_o | output | 1 | Start issued while busy |

## Verification
The assertions assume that `trig_i` and `zc_i` are slow against the clock, so that every level lasts at least one full cycle. They also assume that `sel_i`, `nco_inc_i`, `phase_i` and `busy_i` are quasi-static register values. The stimulus changes all inputs only on falling edges. It holds each trigger level for at least one cycle, keeps `busy_i` constant across each test window, and lets a new `sel_i` settle for several idle cycles before it checks anything.

// File: rtl/trig_src_pkg.sv
package trig_src_pkg;
  typedef enum logic [1:0] {
    SRC_EXT   = 2'd0,
    SRC_NCO   = 2'd1,
    SRC_MAINS = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/trig_nco.sv
module trig_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign {carry_o, sum} = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum;
  end

  // R4
  zero_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/trig_phase_delay.sv
module trig_phase_delay #(
  parameter int PH_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            zc_rise_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            fire_o
);
  logic [PH_W-1:0] cnt_q;
  logic            run_q;

  assign fire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (zc_rise_i) begin
      cnt_q <= phase_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  fire_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && !zc_rise_i) |=> !run_q);
endmodule

// File: rtl/trig_src_top.sv
module trig_src_top
  import trig_src_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [ACC_W-1:0] nco_inc_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             trig_i,
  input  logic             zc_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             overrun_o
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_in;
  logic [N_ASYNC-1:0] async_rise;
  logic               nco_carry;
  logic               mains_fire;
  logic               ev;
  logic               start_d;
  src_e               sel_q;

  assign async_in = {zc_i, trig_i};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    trig_sync_edge #(.STAGES(2)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(async_in[g]),
      .rise_o (async_rise[g])
    );
  end

  trig_nco #(.ACC_W(ACC_W)) u_nco (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (nco_inc_i),
    .carry_o(nco_carry)
  );

  trig_phase_delay #(.PH_W(PH_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zc_rise_i(async_rise[1]),
    .phase_i  (phase_i),
    .fire_o   (mains_fire)
  );

  always_comb begin
    unique case (sel_q)
      SRC_EXT:   ev = async_rise[0];
      SRC_NCO:   ev = nco_carry;
      SRC_MAINS: ev = mains_fire;
      default:   ev = 1'b0;
    endcase
  end

  // drop an event landing on a pulse already out
  assign start_d = ev & ~start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= SRC_NONE;
      start_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (!start_o) sel_q <= src_e'(sel_i);
      start_o   <= start_d;
      overrun_o <= start_d & busy_i;
    end
  end

  // R7
  no_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> $stable(sel_q));

  // R8
  overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> start_o);

  // R6
  none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SRC_NONE) |=> !start_o);
endmodule

// File: tb/sim_trig_src_top.sv
module sim_trig_src_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [31:0] inc = '0;
  logic [15:0] phase = '0;
  logic        trig = 1'b0;
  logic        zc = 1'b0;
  logic        busy = 1'b0;
  logic        start_o;
  logic        overrun_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   sb_en = 1'b0;
  bit   prev_start = 1'b0;
  int   exp_q[$];

  trig_src_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .nco_inc_i(inc),
    .phase_i(phase), .trig_i(trig), .zc_i(zc), .busy_i(busy),
    .start_o(start_o), .overrun_o(overrun_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cyc=%0d", req, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (start_o) chk(overrun_o == busy, "R8", overrun_o, busy);
      else if (overrun_o) chk(1'b0, "R8", 1, 0);
      if (start_o && prev_start) chk(1'b0, "R7 double pulse", 1, 0);
      if (sb_en) begin
        if (start_o) begin
          if (exp_q.size() == 0) chk(1'b0, "R6 unexpected start", cyc, -1);
          else chk(exp_q.pop_front() == cyc, "R2/R5 start cycle", cyc, -1);
        end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
          chk(1'b0, "R2/R5 missed start", -1, exp_q.pop_front());
        end
      end
    end
    prev_start = start_o;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ext_pulse(input int hold, input bit expect_start);
    @(negedge clk);
    trig = 1'b1;
    if (expect_start) exp_q.push_back(cyc + 3); // R2
    idle(hold);
    trig = 1'b0;
    idle(6);
  endtask

  task automatic zc_pulse(input int hold, input bit expect_start);
    @(negedge clk);
    zc = 1'b1;
    if (expect_start) exp_q.push_back(cyc + 4 + int'(phase)); // R5
    idle(hold);
    zc = 1'b0;
    idle(int'(phase) + 8);
  endtask

  task automatic nco_period(input logic [31:0] v, input int per, input string req);
    int last;
    int seen;
    sb_en = 1'b0;
    inc = v;
    sel = 2'd1;
    idle(3 * per + 4);
    last = -1;
    seen = 0;
    while (seen < 6) begin
      @(negedge clk);
      if (start_o) begin
        if (last >= 0) chk(cyc - last == per, req, cyc - last, per);
        last = cyc;
        seen++;
      end
    end
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk(start_o == 0 && overrun_o == 0, "R1 in reset", start_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(start_o == 0 && overrun_o == 0, "R1 after release", start_o, 0);

    // R2 external, long and short trigger levels
    sel = 2'd0;
    idle(4);
    sb_en = 1'b1;
    ext_pulse(10, 1'b1);
    ext_pulse(1, 1'b1);
    ext_pulse(3, 1'b1);
    // R8 overrun with busy
    busy = 1'b1;
    idle(2);
    ext_pulse(2, 1'b1);
    busy = 1'b0;
    idle(2);
    // R6 zc ignored on external source
    zc_pulse(2, 1'b0);

    // R5 mains with phase
    sel = 2'd2;
    idle(4);
    phase = 16'd5;
    zc_pulse(3, 1'b1);
    phase = 16'd0;
    zc_pulse(1, 1'b1);
    phase = 16'd20;
    zc_pulse(2, 1'b1);
    // R6 trig ignored on mains
    ext_pulse(2, 1'b0);

    // R6 off: nothing fires
    sel = 2'd3;
    inc = 32'h4000_0000;
    idle(4);
    ext_pulse(2, 1'b0);
    zc_pulse(2, 1'b0);
    idle(20);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

    // R3 oscillator periods
    nco_period(32'h4000_0000, 4, "R3 period inc 2^30");
    nco_period(32'h1000_0000, 16, "R3 period inc 2^28");
    // R7 carry every cycle collapses to every other cycle
    nco_period(32'hFFFF_FFFF, 2, "R7 back-to-back events");

    // R7 switch away while running: no starts after settle
    sel = 2'd3;
    idle(4);
    sb_en = 1'b1;
    idle(40);

    // R4 zero increment
    sb_en = 1'b0;
    inc = '0;
    sel = 2'd1;
    idle(4);
    sb_en = 1'b1;
    idle(80);
    chk(exp_q.size() == 0, "R4 no starts", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule